// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

The block supervises software through one write port that carries an enable bit and a small key. While stopped, a write with the enable bit set arms it and stores the written key. While armed, software proves it is alive by writing the bitwise inverse of the key it last stored: with the enable bit set, the write restarts the timeout; with it clear, the write disarms the block. A write whose key is not that inverse still replaces the stored key but leaves the timeout running. Because each valid service write flips the key, a runaway loop that keeps writing one constant cannot keep the block quiet.

If no valid service arrives within the first timeout, the block emits a one-cycle non-maskable interrupt pulse and starts a shorter grace interval. A valid restart or stop inside the grace interval cancels the escalation. If the grace interval also runs out, the block drives its chip reset output high for a fixed number of cycles and then returns to the stopped state. All three durations are parameters counted in clock cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low and after it is released, `nmi_o` and `chip_rst_o` are low and the block is stopped, so it raises no interrupt without a write.
- R2: While stopped, a write with `wr_enable`=0 has no effect for any key: no interrupt follows.
- R3: While stopped, a write with `wr_enable`=1 arms the block and stores `wr_key`.
- R4: While armed, a write with `wr_enable`=0 and `wr_key` equal to the bitwise NOT of the stored key disarms the block: no interrupt and no reset follow.
- R5: While armed, a write with `wr_enable`=1 and `wr_key` equal to the bitwise NOT of the stored key restarts the timeout and stores `wr_key`.
- R6: While armed, a write whose key is not the bitwise NOT of the stored key stores `wr_key` (so the next service must use its inverse) and does not restart the timeout.
- R7: `nmi_o` is high for exactly one cycle, in the cycle after the ARM_CYCLES-th clock edge that follows the last arming or restarting write edge.
- R8: If unserviced, `chip_rst_o` rises GRACE_CYCLES edges after the interrupt edge, stays high for HOLD_CYCLES cycles, then falls and the block is stopped.
- R9: A valid restart or stop written during the grace interval cancels the pending reset.
- R10: A valid service write on the same clock edge as a timeout expiry wins: no interrupt (or no reset) is produced at that edge.
- R11: Writes while `chip_rst_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word, one cycle per write |
| wr_enable | input | 1 | Enable bit of the written control word |
| wr_key | input | KEY_W | Key field of the written control word |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse on first expiry |
| chip_rst_o | output | 1 | Chip reset request, high for HOLD_CYCLES cycles |

## Verification
The two functions that can coincide are a timeout expiry and a valid service write. The bench places a restart exactly on the clock edge where the first timeout would expire, and a stop exactly on the edge where the grace interval would expire, by timing the write against its own edge counter. It judges the outcome from the ports: the interrupt must then appear one full timeout after the restart edge, and no reset may appear after the stop.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WARN,
        ST_RESET
    } wd_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_START,
        CMD_STOP,
        CMD_KICK,
        CMD_REKEY
    } wd_cmd_e;

endpackage

// File: rtl/wd_cmd_decode.sv
module wd_cmd_decode
    import wd_pkg::*;
#(
    parameter int KEY_W = 3
) (
    input  logic             active,
    input  logic             locked,
    input  logic             wr_en,
    input  logic             wr_enable,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] key_q,
    output wd_cmd_e          cmd
);

    logic key_match;

    assign key_match = (wr_key == ~key_q);

    always_comb begin
        cmd = CMD_NONE;
        if (wr_en && !locked) begin
            if (!active) begin
                cmd = wr_enable ? CMD_START : CMD_NONE;
            end else if (key_match) begin
                cmd = wr_enable ? CMD_KICK : CMD_STOP;
            end else begin
                cmd = CMD_REKEY;
            end
        end
    end

endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = run && !clr && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wd_pkg::*;
#(
    parameter int KEY_W        = 3,
    parameter int ARM_CYCLES   = 5_000_000,
    parameter int GRACE_CYCLES = 165_000,
    parameter int HOLD_CYCLES  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_enable,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_o,
    output logic             chip_rst_o
);

    typedef struct packed {
        wd_state_e        st;
        logic [KEY_W-1:0] key;
        logic             nmi;
    } regs_t;

    regs_t r_d, r_q;

    wd_cmd_e cmd;
    logic    arm_clr, grace_clr, hold_clr;
    logic    arm_done, grace_done, hold_done;

    logic             [KEY_W-1:0] key_q;
    wd_state_e                    st_q;

    assign key_q = r_q.key;
    assign st_q  = r_q.st;

    wd_cmd_decode #(.KEY_W(KEY_W)) i_decode (
        .active    (r_q.st == ST_RUN || r_q.st == ST_WARN),
        .locked    (r_q.st == ST_RESET),
        .wr_en     (wr_en),
        .wr_enable (wr_enable),
        .wr_key    (wr_key),
        .key_q     (r_q.key),
        .cmd       (cmd)
    );

    wd_timer #(.LIMIT(ARM_CYCLES)) i_arm_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm_clr),
        .run   (r_q.st == ST_RUN),
        .done  (arm_done)
    );

    wd_timer #(.LIMIT(GRACE_CYCLES)) i_grace_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (grace_clr),
        .run   (r_q.st == ST_WARN),
        .done  (grace_done)
    );

    wd_timer #(.LIMIT(HOLD_CYCLES)) i_hold_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_clr),
        .run   (r_q.st == ST_RESET),
        .done  (hold_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.nmi   = 1'b0;
        arm_clr   = 1'b0;
        grace_clr = 1'b0;
        hold_clr  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd == CMD_START) begin
                    r_d.st  = ST_RUN;
                    r_d.key = wr_key;
                    arm_clr = 1'b1;
                end
            end
            ST_RUN, ST_WARN: begin
                if (cmd != CMD_NONE) begin
                    r_d.key = wr_key;
                end
                if (cmd == CMD_STOP) begin
                    r_d.st = ST_IDLE;
                end else if (cmd == CMD_KICK) begin
                    r_d.st  = ST_RUN;
                    arm_clr = 1'b1;
                end else if (r_q.st == ST_RUN && arm_done) begin
                    r_d.st    = ST_WARN;
                    r_d.nmi   = 1'b1;
                    grace_clr = 1'b1;
                end else if (r_q.st == ST_WARN && grace_done) begin
                    r_d.st   = ST_RESET;
                    hold_clr = 1'b1;
                end
            end
            ST_RESET: begin
                if (hold_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.key <= '0;
            r_q.nmi <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign nmi_o      = r_q.nmi;
    assign chip_rst_o = (r_q.st == ST_RESET);

endmodule

// File: rtl/wd_checker.sv
module wd_checker
    import wd_pkg::*;
#(
    parameter int KEY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_enable,
    input logic [KEY_W-1:0] wr_key,
    input logic             nmi_o,
    input logic             chip_rst_o,
    input wd_state_e        st,
    input logic [KEY_W-1:0] key
);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_quiet_in_reset_r1: assert (!nmi_o && !chip_rst_o)
                else $error("outputs active during reset");
        end
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && wr_en && !wr_enable) |=> (st == ST_IDLE));

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && wr_en && wr_enable) |=> (st == ST_RUN && key == $past(wr_key)));

    p_rekey_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN || st == ST_WARN) && wr_en) |=> (key == $past(wr_key)));

    p_nmi_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);

    p_nmi_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (st == ST_WARN));

    p_rst_after_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_o) |-> ($past(st) == ST_WARN));

    p_reset_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESET) |=> (st == ST_RESET || st == ST_IDLE));

endmodule

bind keyed_watchdog wd_checker #(.KEY_W(KEY_W)) i_wd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_enable  (wr_enable),
    .wr_key     (wr_key),
    .nmi_o      (nmi_o),
    .chip_rst_o (chip_rst_o),
    .st         (st_q),
    .key        (key_q)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int KW = 3;
    localparam int T1 = 12;
    localparam int T2 = 5;
    localparam int TR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_enable = 1'b0;
    logic [KW-1:0] wr_key = '0;
    logic          nmi;
    logic          crst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int   nmi_cnt = 0, nmi_edge = -1, rst_cnt = 0, rst_rise = -1, rst_fall = -1;
    logic prev_rst = 1'b0;

    keyed_watchdog #(
        .KEY_W(KW), .ARM_CYCLES(T1), .GRACE_CYCLES(T2), .HOLD_CYCLES(TR)
    ) i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_enable(wr_enable),
        .wr_key(wr_key), .nmi_o(nmi), .chip_rst_o(crst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Samples a quarter period after each rising edge; cyc then names that edge.
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (nmi) begin
            nmi_cnt++;
            nmi_edge = cyc;
        end
        if (crst && !prev_rst) begin
            rst_cnt++;
            rst_rise = cyc;
        end
        if (!crst && prev_rst) rst_fall = cyc;
        prev_rst = crst;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        nmi_cnt = 0; nmi_edge = -1; rst_cnt = 0; rst_rise = -1; rst_fall = -1;
    endtask

    // Called at a falling edge; the write is taken on the next rising edge.
    task automatic wr_now(bit en, logic [KW-1:0] k, output int e);
        wr_en = 1'b1; wr_enable = en; wr_key = k;
        @(negedge clk);
        e = cyc;
        wr_en = 1'b0; wr_enable = 1'b0;
    endtask

    task automatic wr_at(int target, bit en, logic [KW-1:0] k, output int e);
        while (cyc < target - 1) @(negedge clk);
        wr_now(en, k, e);
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int e0, e1, ek, es, exp_n;
        logic [KW-1:0] sk, wk, inv;

        // R1: outputs quiet in reset and after release
        repeat (3) @(negedge clk);
        chk("R1 nmi in reset", int'(nmi), 0);
        chk("R1 rst in reset", int'(crst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        clr_mon();
        wait_to(cyc + 3 * T1);
        chk("R1 idle nmi", nmi_cnt, 0);
        chk("R1 idle rst", rst_cnt, 0);

        // R2: disabled writes while stopped do nothing
        for (int k = 0; k < 8; k++) begin
            clr_mon();
            wr_now(1'b0, KW'(k), e0);
            wait_to(e0 + T1 + T2 + 2);
            chk("R2 no start", nmi_cnt, 0);
        end

        // Sweep of stored key, written key and enable bit (R3..R8)
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 8; w++) begin
                for (int en = 0; en < 2; en++) begin
                    sk  = KW'(s);
                    wk  = KW'(w);
                    inv = ~sk;
                    clr_mon();
                    wr_now(1'b1, sk, e0);              // R3 start
                    wr_at(e0 + 4, en[0], wk, e1);
                    if (wk == inv && en == 0) begin
                        wait_to(e1 + T1 + T2 + TR + 3);
                        chk("R4 stop nmi", nmi_cnt, 0);
                        chk("R4 stop rst", rst_cnt, 0);
                    end else begin
                        if (wk == inv) begin
                            exp_n = e1 + T1;           // R5 restart
                        end else if (en == 0) begin
                            wr_at(e1 + 2, 1'b1, ~wk, ek); // R6 new key serviced
                            exp_n = ek + T1;
                        end else begin
                            exp_n = e0 + T1;           // R6 no restart, R3 timing
                        end
                        wait_to(exp_n + T2 + TR + 3);
                        if (wk == inv)
                            chk("R5 nmi edge", nmi_edge, exp_n);
                        else
                            chk("R6 nmi edge", nmi_edge, exp_n);
                        chk("R7 nmi width", nmi_cnt, 1);
                        chk("R8 rst rise", rst_rise, exp_n + T2);
                        chk("R8 rst fall", rst_fall, exp_n + T2 + TR);
                    end
                end
            end
        end

        // R9: restart then stop inside the grace interval
        clr_mon();
        wr_now(1'b1, 3'd2, e0);
        wr_at(e0 + T1 + 2, 1'b1, 3'd5, ek);
        wr_at(ek + T1 + 1, 1'b0, 3'd2, es);
        wait_to(es + T1 + T2 + TR + 3);
        chk("R9 nmi count", nmi_cnt, 2);
        chk("R9 second nmi", nmi_edge, ek + T1);
        chk("R9 no reset", rst_cnt, 0);

        // R10: service on the expiry edges
        clr_mon();
        wr_now(1'b1, 3'd1, e0);
        wr_at(e0 + T1, 1'b1, 3'd6, ek);
        wr_at(ek + T1 + T2, 1'b0, 3'd1, es);
        wait_to(es + T1 + T2 + TR + 3);
        chk("R10 nmi count", nmi_cnt, 1);
        chk("R10 nmi edge", nmi_edge, ek + T1);
        chk("R10 no reset", rst_cnt, 0);

        // R11: writes during the reset pulse are ignored
        clr_mon();
        wr_now(1'b1, 3'd4, e0);
        wr_at(e0 + T1 + T2 + 1, 1'b1, 3'd3, e1);
        wait_to(e0 + T1 + T2 + TR + T1 + 4);
        chk("R11 nmi count", nmi_cnt, 1);
        chk("R11 rst count", rst_cnt, 1);
        chk("R11 rst fall", rst_fall, e0 + T1 + T2 + TR);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule